// File: doc/BRIEF.md
# CAN Controller Control and Status Register Block

This block holds the software-visible control state of a CAN controller and a shadow copy of the status that the protocol engine reports. Software reaches it over a simple synchronous register bus with an address, a write enable, byte-lane write strobes, write data, a read strobe and combinational read data. The control word selects configuration mode, the interrupt enables, automatic-retransmission suppression, configuration-change permission and test mode. These settings are driven out to the rest of the controller.

The bit-timing word reaches the bit-timing logic only through a guarded path. A write to it takes effect only while configuration changes are permitted and the controller is in configuration mode. The protocol engine pushes status updates: a three-bit last-error code, a bus-off flag and an error-warning flag. If the error interrupt is enabled, a change in either flag latches an error-pending flag. Entering bus-off forces the controller back into configuration mode.

Top module: `can_ctrl_regs`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x0000_0001, the bit-timing word (offset 0x08) reads the parameter default (0x2301 with default parameters), the status word (offset 0x04) reads 0 and the interrupt output is low.
- R2: Control bits are: bit 0 configuration mode, bit 1 interrupt enable, bit 2 status interrupt enable, bit 3 error interrupt enable, bit 5 retransmission disable, bit 6 configuration-change enable, bit 7 test mode. Bit 4, bits 31:8 and any unmapped offset read as zero and ignore writes.
- R3: Only the byte lanes whose write strobe is 1 are written. The control word lives in lane 0.
- R4: A bit-timing write is applied only when configuration-change enable and configuration mode are both 1; otherwise the word keeps its value. Bits above the bit-timing width read as zero.
- R5: On a cycle with the engine update strobe high, the status shadow takes the engine's values. Without the strobe it holds. Status layout: last-error code bits 2:0, warning flag bit 6, bus-off flag bit 7.
- R6: With error interrupt enable set, an update that changes the bus-off or warning flag sets the error-pending flag. An update that changes only the error code does not set it, and no update sets it while the enable is clear.
- R7: The interrupt output equals the pending flag ANDed with interrupt enable. A status read (read strobe at offset 0x04) clears the pending flag, and a new setting in the same cycle wins over the clear.
- R8: An update that takes the bus-off flag from 0 to 1 sets configuration mode, even against a software write clearing it in the same cycle. An update where bus-off stays 1 does not.
- R9: Configuration mode, retransmission disable, test mode and the bit-timing word are driven on output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_rdata | output | 32 | Combinational read data |
| eng_upd | input | 1 | Status update strobe from the protocol engine |
| eng_lec | input | 3 | Last-error code from the engine |
| eng_bus_off | input | 1 | Bus-off flag from the engine |
| eng_warn | input | 1 | Error-warning flag from the engine |
| init_mode | output | 1 | Configuration mode |
| no_retx | output | 1 | Automatic retransmission disabled |
| test_mode | output | 1 | Test mode enabled |
| bt_cfg | output | BT_W | Current bit-timing word |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit bit-timing word with reset value 0x2301. This gives two bit-timing byte lanes, so a partial-lane write and the zero upper half can both be seen. It also lets a full-word write show that bits above the width are dropped. The whole control byte fits in lane 0, so strobing only lanes 1 to 3 shows that the control word is left untouched.

// File: rtl/can_regs_pkg.sv
package can_regs_pkg;

    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] OFS_CTL  = 8'h00;
    localparam logic [AW-1:0] OFS_STAT = 8'h04;
    localparam logic [AW-1:0] OFS_BT   = 8'h08;

    localparam int CTL_INIT = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_SIE  = 2;
    localparam int CTL_EIE  = 3;
    localparam int CTL_DAR  = 5;
    localparam int CTL_CCE  = 6;
    localparam int CTL_TEST = 7;

    localparam logic [7:0] CTL_WMASK = 8'hEF;
    localparam logic [7:0] CTL_RST   = 8'h01;

    typedef struct packed {
        logic       bus_off;
        logic       warn;
        logic [2:0] lec;
    } stat_t;

endpackage

// File: rtl/can_ctl_reg.sv
module can_ctl_reg
    import can_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    input  logic       hw_set_init,
    output logic [7:0] ctl
);

    typedef struct packed {
        logic [7:0] ctl;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctl = wbyte & CTL_WMASK;
        end
        if (hw_set_init) begin
            st_d.ctl[CTL_INIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl <= CTL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl = st_q.ctl;

    // R8
    hw_init_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_init |=> ctl[CTL_INIT]);

    // R2
    ctl_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl[4] == 1'b0));

endmodule

// File: rtl/can_bt_reg.sv
module can_bt_reg #(
    parameter int              BT_W   = 16,
    parameter logic [BT_W-1:0] BT_RST = 16'h2301,
    parameter int              NB     = BT_W / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel,
    input  logic [NB-1:0]   be,
    input  logic [BT_W-1:0] wdata,
    input  logic            cfg_ok,
    output logic [BT_W-1:0] bt
);

    typedef struct packed {
        logic [BT_W-1:0] bt;
    } bt_state_t;

    bt_state_t st_d, st_q;
    logic [BT_W-1:0] lane_next;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane_next[g*8 +: 8] = (wr_sel && cfg_ok && be[g]) ?
                                     wdata[g*8 +: 8] : st_q.bt[g*8 +: 8];
    end

    always_comb begin
        st_d    = st_q;
        st_d.bt = lane_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bt <= BT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bt = st_q.bt;

    // R4
    bt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> $stable(bt));

endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
    import can_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd,
    input  stat_t upd_val,
    input  logic  err_ie,
    input  logic  stat_rd,
    output stat_t stat,
    output logic  pend,
    output logic  bus_off_rise
);

    typedef struct packed {
        stat_t stat;
        logic  pend;
    } si_state_t;

    si_state_t st_d, st_q;
    logic      flag_chg;
    logic      pend_set;

    always_comb begin
        st_d         = st_q;
        flag_chg     = upd && ((upd_val.bus_off != st_q.stat.bus_off) ||
                               (upd_val.warn    != st_q.stat.warn));
        pend_set     = flag_chg && err_ie;
        bus_off_rise = upd && upd_val.bus_off && !st_q.stat.bus_off;
        if (upd) begin
            st_d.stat = upd_val;
        end
        if (stat_rd) begin
            st_d.pend = 1'b0;
        end
        if (pend_set) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
    assign pend = st_q.pend;

    // R5
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(stat));

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && err_ie && (upd_val.warn != stat.warn)) |=> pend);

    // R7
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !upd) |=> !pend);

endmodule

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
    import can_regs_pkg::*;
#(
    parameter int              BT_W   = 16,
    parameter logic [BT_W-1:0] BT_RST = 16'h2301
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      bus_addr,
    input  logic            bus_we,
    input  logic [3:0]      bus_be,
    input  logic [31:0]     bus_wdata,
    input  logic            bus_rd,
    output logic [31:0]     bus_rdata,
    input  logic            eng_upd,
    input  logic [2:0]      eng_lec,
    input  logic            eng_bus_off,
    input  logic            eng_warn,
    output logic            init_mode,
    output logic            no_retx,
    output logic            test_mode,
    output logic [BT_W-1:0] bt_cfg,
    output logic            err_irq
);

    localparam int NB = BT_W / 8;

    logic [7:0] ctl;
    stat_t      stat;
    stat_t      upd_val;
    logic       pend;
    logic       bus_off_rise;
    logic       sel_ctl, sel_stat, sel_bt;
    logic       unused_bits;

    assign sel_ctl  = (bus_addr == OFS_CTL);
    assign sel_stat = (bus_addr == OFS_STAT);
    assign sel_bt   = (bus_addr == OFS_BT);
    assign upd_val  = '{bus_off: eng_bus_off, warn: eng_warn, lec: eng_lec};
    assign unused_bits = ^{bus_wdata[31:BT_W], bus_be[3:NB], ctl[CTL_SIE]};

    can_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_we && sel_ctl && bus_be[0]),
        .wbyte       (bus_wdata[7:0]),
        .hw_set_init (bus_off_rise),
        .ctl         (ctl)
    );

    can_bt_reg #(
        .BT_W   (BT_W),
        .BT_RST (BT_RST),
        .NB     (NB)
    ) u_bt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (bus_we && sel_bt),
        .be     (bus_be[NB-1:0]),
        .wdata  (bus_wdata[BT_W-1:0]),
        .cfg_ok (ctl[CTL_CCE] && ctl[CTL_INIT]),
        .bt     (bt_cfg)
    );

    can_stat_irq u_si (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd          (eng_upd),
        .upd_val      (upd_val),
        .err_ie       (ctl[CTL_EIE]),
        .stat_rd      (bus_rd && sel_stat),
        .stat         (stat),
        .pend         (pend),
        .bus_off_rise (bus_off_rise)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_ctl) begin
            bus_rdata[7:0] = ctl;
        end else if (sel_stat) begin
            bus_rdata[2:0] = stat.lec;
            bus_rdata[6]   = stat.warn;
            bus_rdata[7]   = stat.bus_off;
        end else if (sel_bt) begin
            bus_rdata[BT_W-1:0] = bt_cfg;
        end
    end

    assign init_mode = ctl[CTL_INIT];
    assign no_retx   = ctl[CTL_DAR];
    assign test_mode = ctl[CTL_TEST];
    assign err_irq   = pend && ctl[CTL_IE];

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ctl[CTL_IE]);

endmodule

// File: tb/tb_can_ctrl_regs.sv
module tb_can_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        eng_upd = 1'b0;
    logic [2:0]  eng_lec = '0;
    logic        eng_bus_off = 1'b0;
    logic        eng_warn = 1'b0;
    logic        init_mode, no_retx, test_mode, err_irq;
    logic [15:0] bt_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .eng_upd(eng_upd), .eng_lec(eng_lec),
        .eng_bus_off(eng_bus_off), .eng_warn(eng_warn),
        .init_mode(init_mode), .no_retx(no_retx), .test_mode(test_mode),
        .bt_cfg(bt_cfg), .err_irq(err_irq)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  wa;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 4'h1, 32'hFFFF_FFFF, 8'h00, 32'h0000_00EF, 4'd2}, // R2
        '{1'b1, 8'h08, 4'h3, 32'h0000_1234, 8'h08, 32'h0000_1234, 4'd4}, // R4
        '{1'b1, 8'h08, 4'h2, 32'h0000_AB00, 8'h08, 32'h0000_AB34, 4'd3}, // R3
        '{1'b1, 8'h00, 4'h1, 32'h0000_0041, 8'h00, 32'h0000_0041, 4'd2}, // R2
        '{1'b1, 8'h00, 4'h1, 32'h0000_0040, 8'h00, 32'h0000_0040, 4'd2}, // R2
        '{1'b1, 8'h08, 4'h3, 32'h0000_5555, 8'h08, 32'h0000_AB34, 4'd4}, // R4
        '{1'b1, 8'h00, 4'h1, 32'h0000_0001, 8'h00, 32'h0000_0001, 4'd2}, // R2
        '{1'b1, 8'h08, 4'h3, 32'h0000_7777, 8'h08, 32'h0000_AB34, 4'd4}, // R4
        '{1'b1, 8'h00, 4'hE, 32'hFFFF_FF00, 8'h00, 32'h0000_0001, 4'd3}, // R3
        '{1'b1, 8'h00, 4'h1, 32'h0000_0041, 8'h00, 32'h0000_0041, 4'd2}, // R2
        '{1'b1, 8'h08, 4'h1, 32'h0000_0099, 8'h08, 32'h0000_AB99, 4'd3}, // R3
        '{1'b1, 8'h08, 4'hF, 32'hFFFF_0000, 8'h08, 32'h0000_0000, 4'd4}, // R4
        '{1'b1, 8'h0C, 4'hF, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000, 4'd2}, // R2
        '{1'b0, 8'h00, 4'h0, 32'h0000_0000, 8'h04, 32'h0000_0000, 4'd5}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic stat_read();
        @(negedge clk);
        bus_addr = 8'h04; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic eng(input logic bo, input logic w, input logic [2:0] lec);
        @(negedge clk);
        eng_upd = 1'b1; eng_bus_off = bo; eng_warn = w; eng_lec = lec;
        @(negedge clk);
        eng_upd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        peek(8'h00, rv); check("R1 ctl", rv, 32'h1);
        peek(8'h08, rv); check("R1 bt", rv, 32'h2301);
        peek(8'h04, rv); check("R1 stat", rv, 32'h0);
        check("R1 irq", {31'b0, err_irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].wa, VECS[i].be, VECS[i].wd);
            else @(negedge clk);
            peek(VECS[i].ra, rv);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), rv, VECS[i].exp);
        end

        // R9 exported values
        wr(8'h08, 4'h3, 32'h2A5C);
        check("R9 bt_cfg", {16'b0, bt_cfg}, 32'h2A5C);
        wr(8'h00, 4'h1, 32'hA1);
        check("R9 outputs", {29'b0, init_mode, no_retx, test_mode}, 32'h7);

        // R5 status shadow
        eng(1'b0, 1'b0, 3'd5);
        peek(8'h04, rv); check("R5 update", rv, 32'h05);
        @(negedge clk); eng_lec = 3'd2; eng_warn = 1'b1;
        @(negedge clk); @(negedge clk);
        peek(8'h04, rv); check("R5 hold", rv, 32'h05);

        // R6 / R7 error interrupt
        wr(8'h00, 4'h1, 32'h0B);
        eng(1'b0, 1'b0, 3'd3);
        check("R6 code only", {31'b0, err_irq}, 32'h0);
        eng(1'b0, 1'b1, 3'd3);
        check("R6 warn change", {31'b0, err_irq}, 32'h1);
        peek(8'h04, rv); check("R5 layout", rv, 32'h43);
        stat_read();
        check("R7 read clears", {31'b0, err_irq}, 32'h0);
        wr(8'h00, 4'h1, 32'h09);
        eng(1'b0, 1'b0, 3'd3);
        check("R7 masked", {31'b0, err_irq}, 32'h0);
        wr(8'h00, 4'h1, 32'h0B);
        check("R7 unmasked", {31'b0, err_irq}, 32'h1);
        stat_read();
        wr(8'h00, 4'h1, 32'h03);
        eng(1'b0, 1'b1, 3'd3);
        wr(8'h00, 4'h1, 32'h0B);
        check("R6 disabled", {31'b0, err_irq}, 32'h0);

        // R8 hardware entry to configuration mode
        wr(8'h00, 4'h1, 32'h00);
        check("R9 init out", {31'b0, init_mode}, 32'h0);
        @(negedge clk);
        bus_addr = 8'h00; bus_we = 1'b1; bus_be = 4'h1; bus_wdata = 32'h0;
        eng_upd = 1'b1; eng_bus_off = 1'b1; eng_warn = 1'b1; eng_lec = 3'd3;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0; eng_upd = 1'b0;
        peek(8'h00, rv); check("R8 hw wins", rv, 32'h01);
        peek(8'h04, rv); check("R5 bus-off bit", rv, 32'hC3);
        wr(8'h00, 4'h1, 32'h00);
        eng(1'b1, 1'b1, 3'd3);
        check("R8 no rise", {31'b0, init_mode}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule